// File: doc/BRIEF.md
# Saturating-Age Replacement Selector

This block keeps a small age counter for every way of every set in an N-way set-associative cache and names the way to replace when the cache misses. The surrounding cache presents a set index every cycle. When the access hits, it pulses a hit strobe with the matching way. When a line has been filled, it pulses an allocate strobe with the filled way. When a line is dropped, it pulses an invalidate strobe with the cleared way. The block updates the ages of the indexed set on the clock edge. The victim output is a combinational function of the currently indexed set. Tags and line data are kept elsewhere.

Each counter saturates at a top value that is one less than the configured number of usage states. The usage-state count is a parameter, from 2 to 4. A recently used way holds the top value and ages downward as other ways are touched. The rules for aging differ between a hit and an allocate.

Top module: `lru_age_unit`

## Requirements
- R1: After reset every counter is zero, so the victim for every set is way 0.
- R2: The parameter STATES lies between 2 and 4 inclusive. The top counter value is STATES-1, and no counter ever exceeds it.
- R3: On a hit, every way of the indexed set whose counter is strictly greater than the hit way's counter drops by one. The hit way then takes the top value. A hit on a way already at the top value changes nothing.
- R4: On an allocate, every way of the indexed set with a nonzero counter drops by one, and the filled way takes the top value.
- R5: The victim is the way with the smallest counter that is strictly below the top value. When several ways tie, the lowest-numbered of them is chosen.
- R6: When every way of the indexed set is at the top value, the victim is way 0.
- R7: An invalidate sets the counter of the named way to zero and leaves the other ways of the set alone.
- R8: An update touches only the indexed set. The victims of all other sets are unchanged.
- R9: The victim follows a change of set index in the same cycle, with no clock edge in between.
- R10: At most one of the three strobes is high in a cycle. In a cycle with no strobe, no counter changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_idx | input | log2(SETS) | Set being accessed |
| hit_en | input | 1 | Access hit in the indexed set |
| hit_way | input | log2(WAYS) | Way that hit |
| alloc_en | input | 1 | A line was filled in the indexed set |
| alloc_way | input | log2(WAYS) | Way that was filled |
| inv_en | input | 1 | A line of the indexed set is cleared |
| inv_way | input | log2(WAYS) | Way that is cleared |
| victim_way | output | log2(WAYS) | Way to replace in the indexed set |

## Verification
The update rules keep at most one way of a set at the top value. As a result, the all-at-top fallback of R6 cannot be reached from the ports when there are two or more ways. The bench therefore adds a single-way instance, where one allocate puts the only counter at the top value. The main sweep drives a long pseudo-random mix of hits, allocates, invalidates and idle cycles into three instances that differ only in STATES. After every operation it walks the set index across all sets within one low clock phase and compares each victim with an arithmetic model. This catches rule errors, leakage between sets and any registered delay on the victim path.

// File: rtl/lru_age_unit.sv
module lru_age_unit #(
  parameter int WAYS   = 4,
  parameter int SETS   = 16,
  parameter int STATES = 4
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [(SETS > 1 ? $clog2(SETS) : 1)-1:0] set_idx,
  input  logic                                  hit_en,
  input  logic [(WAYS > 1 ? $clog2(WAYS) : 1)-1:0] hit_way,
  input  logic                                  alloc_en,
  input  logic [(WAYS > 1 ? $clog2(WAYS) : 1)-1:0] alloc_way,
  input  logic                                  inv_en,
  input  logic [(WAYS > 1 ? $clog2(WAYS) : 1)-1:0] inv_way,
  output logic [(WAYS > 1 ? $clog2(WAYS) : 1)-1:0] victim_way
);
  localparam int IW = (SETS > 1) ? $clog2(SETS) : 1;
  localparam int WW = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int CW = $clog2(STATES);
  localparam logic [CW-1:0] TOP = CW'(STATES - 1);

  logic [CW-1:0] age_q [SETS][WAYS];
  logic [CW-1:0] cur   [WAYS];
  logic [CW-1:0] nxt   [WAYS];
  logic [CW-1:0] best;
  logic [CW-1:0] hit_age;
  logic          upd;

  assign upd = hit_en | alloc_en | inv_en;

  always_comb begin
    for (int w = 0; w < WAYS; w++) cur[w] = age_q[set_idx][w];
  end

  always_comb begin
    victim_way = '0;
    best       = TOP;
    for (int w = 0; w < WAYS; w++) begin
      if (cur[w] < best) begin
        best       = cur[w];
        victim_way = WW'(w);
      end
    end
  end

  assign hit_age = cur[hit_way];

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      nxt[w] = cur[w];
      if (hit_en) begin
        if (WW'(w) == hit_way)    nxt[w] = TOP;
        else if (cur[w] > hit_age) nxt[w] = cur[w] - 1'b1;
      end else if (alloc_en) begin
        if (WW'(w) == alloc_way)  nxt[w] = TOP;
        else if (cur[w] != '0)     nxt[w] = cur[w] - 1'b1;
      end else if (inv_en) begin
        if (WW'(w) == inv_way)    nxt[w] = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= '0;
    end else if (upd) begin
      for (int w = 0; w < WAYS; w++) age_q[set_idx][w] <= nxt[w];
    end
  end

  logic [IW-1:0] unused_iw;
  assign unused_iw = set_idx;
endmodule

// File: rtl/lru_age_unit_chk.sv
module lru_age_unit_chk #(
  parameter int WAYS   = 4,
  parameter int SETS   = 16,
  parameter int STATES = 4
) (
  input logic                                     clk,
  input logic                                     rst_n,
  input logic [(SETS > 1 ? $clog2(SETS) : 1)-1:0] set_idx,
  input logic                                     hit_en,
  input logic [(WAYS > 1 ? $clog2(WAYS) : 1)-1:0] hit_way,
  input logic                                     alloc_en,
  input logic [(WAYS > 1 ? $clog2(WAYS) : 1)-1:0] alloc_way,
  input logic                                     inv_en,
  input logic [(WAYS > 1 ? $clog2(WAYS) : 1)-1:0] inv_way,
  input logic [(WAYS > 1 ? $clog2(WAYS) : 1)-1:0] victim_way,
  input logic [$clog2(STATES)-1:0]                age_q [SETS][WAYS]
);
  localparam int IW = (SETS > 1) ? $clog2(SETS) : 1;
  localparam int WW = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int CW = $clog2(STATES);
  localparam logic [CW-1:0] TOP = CW'(STATES - 1);

  logic [IW-1:0] lst_set;
  logic [WW-1:0] lst_way;
  logic          lst_hit, lst_alloc, lst_inv;
  logic [WAYS-1:0] at_top;
  logic [CW-1:0] lst_age;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lst_set <= '0; lst_way <= '0;
      lst_hit <= 1'b0; lst_alloc <= 1'b0; lst_inv <= 1'b0;
    end else begin
      lst_set   <= set_idx;
      lst_way   <= hit_en ? hit_way : (alloc_en ? alloc_way : inv_way);
      lst_hit   <= hit_en;
      lst_alloc <= alloc_en;
      lst_inv   <= inv_en;
    end
  end

  always_comb begin
    for (int w = 0; w < WAYS; w++) at_top[w] = (age_q[set_idx][w] == TOP);
  end

  assign lst_age = age_q[lst_set][lst_way];

  AST_ONE_STROBE:   assert property (@(posedge clk) disable iff (!rst_n) $countones({hit_en, alloc_en, inv_en}) <= 1); // R10
  AST_HIT_TOP:      assert property (@(posedge clk) disable iff (!rst_n) lst_hit |-> lst_age == TOP); // R3
  AST_ALLOC_TOP:    assert property (@(posedge clk) disable iff (!rst_n) lst_alloc |-> lst_age == TOP); // R4
  AST_INV_ZERO:     assert property (@(posedge clk) disable iff (!rst_n) lst_inv |-> lst_age == '0); // R7
  AST_SINGLE_TOP:   assert property (@(posedge clk) disable iff (!rst_n) $countones(at_top) <= 1); // R2
  AST_VICTIM_BELOW: assert property (@(posedge clk) disable iff (!rst_n) (~at_top != '0) |-> age_q[set_idx][victim_way] != TOP); // R5
  AST_ALL_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (&at_top) |-> victim_way == '0); // R6
endmodule

bind lru_age_unit lru_age_unit_chk #(.WAYS(WAYS), .SETS(SETS), .STATES(STATES)) chk_i (.*);

// File: tb/lru_age_unit_tb_top.sv
module lru_age_unit_tb_top;
  localparam int WAYS = 4;
  localparam int SETS = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n;
  logic [2:0] set_idx;
  logic       hit_en, alloc_en, inv_en;
  logic [1:0] hit_way, alloc_way, inv_way;
  logic [1:0] vic2, vic3, vic4;
  logic       w1_alloc, w1_hit, w1_vic;

  int mdl [3][SETS][WAYS];
  int checks = 0;
  int errors = 0;
  logic [15:0] lfsr = 16'hACE1;

  lru_age_unit #(.WAYS(WAYS), .SETS(SETS), .STATES(2)) dut_s2_i (
    .clk(clk), .rst_n(rst_n), .set_idx(set_idx), .hit_en(hit_en), .hit_way(hit_way),
    .alloc_en(alloc_en), .alloc_way(alloc_way), .inv_en(inv_en), .inv_way(inv_way), .victim_way(vic2));
  lru_age_unit #(.WAYS(WAYS), .SETS(SETS), .STATES(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .set_idx(set_idx), .hit_en(hit_en), .hit_way(hit_way),
    .alloc_en(alloc_en), .alloc_way(alloc_way), .inv_en(inv_en), .inv_way(inv_way), .victim_way(vic3));
  lru_age_unit #(.WAYS(WAYS), .SETS(SETS), .STATES(4)) dut_s4_i (
    .clk(clk), .rst_n(rst_n), .set_idx(set_idx), .hit_en(hit_en), .hit_way(hit_way),
    .alloc_en(alloc_en), .alloc_way(alloc_way), .inv_en(inv_en), .inv_way(inv_way), .victim_way(vic4));
  lru_age_unit #(.WAYS(1), .SETS(2), .STATES(2)) dut_w1_i (
    .clk(clk), .rst_n(rst_n), .set_idx(set_idx[0]), .hit_en(w1_hit), .hit_way(1'b0),
    .alloc_en(w1_alloc), .alloc_way(1'b0), .inv_en(1'b0), .inv_way(1'b0), .victim_way(w1_vic));

  function automatic int exp_vic(int c, int s);
    int top = c + 1;
    int lo  = top;
    int v   = 0;
    for (int w = 0; w < WAYS; w++)
      if (mdl[c][s][w] < lo) begin lo = mdl[c][s][w]; v = w; end
    return v;
  endfunction

  task automatic chk(string tag, int got, int exp, int s, int st);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s set %0d states %0d victim actual %0d expected %0d", tag, s, st, got, exp);
    end
  endtask

  task automatic check_all(string tag);
    for (int s = 0; s < SETS; s++) begin
      set_idx = 3'(s);
      #1;
      chk(tag, int'(vic2), exp_vic(0, s), s, 2);
      chk(tag, int'(vic3), exp_vic(1, s), s, 3);
      chk(tag, int'(vic4), exp_vic(2, s), s, 4);
    end
  endtask

  // kind: 0 hit, 1 allocate, 2 invalidate, 3 idle
  task automatic apply(int kind, int s, int w, string tag);
    @(negedge clk);
    set_idx   = 3'(s);
    hit_en    = (kind == 0); hit_way   = 2'(w);
    alloc_en  = (kind == 1); alloc_way = 2'(w);
    inv_en    = (kind == 2); inv_way   = 2'(w);
    @(posedge clk);
    for (int c = 0; c < 3; c++) begin
      int top = c + 1;
      int ref_age = mdl[c][s][w];
      for (int x = 0; x < WAYS; x++) begin
        if (kind == 0) begin
          if (x == w) mdl[c][s][x] = top;
          else if (mdl[c][s][x] > ref_age) mdl[c][s][x]--;
        end else if (kind == 1) begin
          if (x == w) mdl[c][s][x] = top;
          else if (mdl[c][s][x] != 0) mdl[c][s][x]--;
        end else if (kind == 2) begin
          if (x == w) mdl[c][s][x] = 0;
        end
      end
    end
    @(negedge clk);
    hit_en = 1'b0; alloc_en = 1'b0; inv_en = 1'b0;
    check_all(tag);
  endtask

  initial begin
    #(20 * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; set_idx = '0;
    hit_en = 1'b0; alloc_en = 1'b0; inv_en = 1'b0;
    hit_way = '0; alloc_way = '0; inv_way = '0;
    w1_alloc = 1'b0; w1_hit = 1'b0;
    for (int c = 0; c < 3; c++)
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) mdl[c][s][w] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_all("R1/R5/R9");

    // R4 then R3: hit on the way already at the top is a no-op
    apply(1, 0, 2, "R4");
    apply(0, 0, 2, "R3");
    apply(1, 0, 1, "R4/R8");
    apply(0, 0, 2, "R3/R5");
    apply(2, 0, 2, "R7");
    apply(3, 0, 0, "R10");
    // R2: repeated allocates age a way back down to zero
    for (int k = 0; k < 4; k++) apply(1, 5, k, "R2/R4");
    for (int k = 3; k >= 0; k--) apply(0, 5, k, "R2/R3");

    for (int n = 0; n < 1500; n++) begin
      int r, s, w, kind;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      r = int'(lfsr);
      s = r % SETS;
      w = (r >> 3) % WAYS;
      case ((r >> 5) % 8)
        0, 1, 2: kind = 0;
        3, 4, 5: kind = 1;
        6:       kind = 2;
        default: kind = 3;
      endcase
      apply(kind, s, w, "R2/R3/R4/R5/R7/R8/R10");
    end

    // R6: single way, once allocated it sits at the top value
    @(negedge clk);
    set_idx = 3'd1;
    #1 chk("R1/R6", int'(w1_vic), 0, 1, 2);
    w1_alloc = 1'b1;
    @(negedge clk);
    w1_alloc = 1'b0;
    #1 chk("R6", int'(w1_vic), 0, 1, 2);
    w1_hit = 1'b1;
    @(negedge clk);
    w1_hit = 1'b0;
    #1 chk("R6", int'(w1_vic), 0, 1, 2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule